// File: doc/BRIEF.md
# Synchronous Burst Read Controller for Pseudo-Static RAM

This block sits on the host side of a pseudo-static RAM with a multiplexed, clocked control interface and performs fixed-length burst reads. A client raises `req_go` with an address while `req_ready` is high. The controller opens the transaction by pulling chip select low together with a single-cycle address-valid strobe, and keeps output enable and the byte enables low while write enable stays high. It then waits a fixed first-word latency and collects the burst, one word per clock edge at which the memory's active-low wait line reports data available. Each word appears on `rd_valid`/`rd_data`, and `rd_last` marks the final word.

When the burst ends, chip select goes high and stays high for a minimum recovery time before the next request can be accepted. So consecutive bursts are always separated by a chip-select pulse. Two guards end a transaction early. One applies when the wait line stays low for too long after the latency point: the burst is abandoned and `tmo_err` is raised. The other applies when chip select has been low for the maximum allowed number of cycles, which keeps the total burst cycle time within the memory's limit: the burst is cut and `lim_err` is raised. Both flags hold until the next request is accepted.

Top module: `psram_burst_reader`

## Requirements
- R1: A request is accepted only at a clock edge where `req_ready` is high (idle). At that edge the controller drives `mem_addr` with `req_addr` and pulls `mem_cs_n` and `mem_adv_n` low. A `req_go` seen while busy is ignored and does not change `mem_addr`.
- R2: Each burst has exactly one cycle with `mem_adv_n` low. That cycle is the first cycle of chip select low, and the requested address is on `mem_addr` throughout it.
- R3: The first word is taken at the edge LATENCY cycles after the address edge, provided `mem_wait_n` is 1 there. Each extra cycle of `mem_wait_n` low delays it by one edge. A taken word appears on `rd_valid`/`rd_data` in the following cycle.
- R4: A burst delivers BURST_LEN words, each taken only at an edge where `mem_wait_n` is 1, so a mid-burst stall delays the remaining words. `rd_last` is high with the final word only.
- R5: `mem_oe_n` is 0 and every bit of `mem_be_n` is 0 in every cycle in which `mem_cs_n` is 0. `mem_we_n` is 1 at all times.
- R6: `mem_cs_n` rises at the edge that takes the final word. It then stays high for at least CS_HIGH_MIN+1 cycles before the next burst. `busy` stays high until CS_HIGH_MIN cycles after the rise.
- R7: If `mem_wait_n` is 0 at the latency edge and at each of the WAIT_TO edges after it, the burst ends at the last of those edges with no word delivered. `tmo_err` then reads 1 until the next accepted request.
- R8: `mem_cs_n` is never low for more than MAX_CS_LOW consecutive cycles. A burst that reaches the limit ends there, keeps the words taken up to and including that edge, gives no `rd_last`, and sets `lim_err` until the next accepted request.
- R9: `mem_wait_n` and `mem_dq` are ignored while `mem_cs_n` is high: `rd_valid` stays 0 and `rd_data` holds its value.
- R10: After reset, `mem_cs_n`, `mem_adv_n`, `mem_oe_n` and `mem_we_n` are 1 and `mem_be_n` is all ones. `req_ready` is 1, and `busy`, `rd_valid`, `tmo_err` and `lim_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_go | input | 1 | Request strobe, taken while `req_ready` is high |
| req_addr | input | AW | Start address of the burst |
| req_ready | output | 1 | Controller idle and able to accept a request |
| busy | output | 1 | Transaction or chip-select recovery in progress |
| rd_valid | output | 1 | `rd_data` holds a word of the burst |
| rd_data | output | DW | Returned data word |
| rd_last | output | 1 | Final word of the burst |
| tmo_err | output | 1 | Last burst was abandoned on wait timeout |
| lim_err | output | 1 | Last burst was cut at the chip-select low limit |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, held high |
| mem_be_n | output | BE_W | Byte enables, active low |
| mem_addr | output | AW | Address to the memory |
| mem_wait_n | input | 1 | Memory wait line, 0 = data not yet available |
| mem_dq | input | DW | Data from the memory |

## Verification
Counted from the accepting edge E0, the address edge is E0+1. Word j is taken at edge E0+1+LATENCY+d+j, plus the stall length for words after a stall, where d is the extra wait delay. It shows on `rd_valid` in the cycle that follows. Chip select rises at the edge of the final word, of the timeout (E0+1+LATENCY+WAIT_TO) or of the limit (E0+MAX_CS_LOW), and `busy` drops CS_HIGH_MIN edges later. The bench drives inputs and samples outputs on the falling clock edge. It numbers each falling edge after E0 and compares every event against the index predicted from these formulas, with no window of tolerance.

// File: rtl/prd_pkg.sv
package prd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_LAT   = 3'd2,
    ST_DATA  = 3'd3,
    ST_RECOV = 3'd4
  } prd_state_e;

endpackage

// File: rtl/prd_counter.sv
module prd_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    if (clr)     cnt_nx = '0;
    else if (en) cnt_nx = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

endmodule

// File: rtl/prd_capture.sv
module prd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          last,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= take;
      rd_last  <= take & last;
    end
  end

  // data register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_data <= '0;
    else if (take) rd_data <= dq_in;
  end

  AST_LAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> !rd_last); // R4

endmodule

// File: rtl/psram_burst_reader.sv
module psram_burst_reader
  import prd_pkg::*;
#(
  parameter int AW          = 22,
  parameter int DW          = 16,
  parameter int BE_W        = 2,
  parameter int LATENCY     = 5,
  parameter int BURST_LEN   = 4,
  parameter int CS_HIGH_MIN = 1,
  parameter int MAX_CS_LOW  = 250,
  parameter int WAIT_TO     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_go,
  input  logic [AW-1:0]   req_addr,
  output logic            req_ready,
  output logic            busy,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            rd_last,
  output logic            tmo_err,
  output logic            lim_err,
  output logic            mem_cs_n,
  output logic            mem_adv_n,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic [BE_W-1:0] mem_be_n,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_wait_n,
  input  logic [DW-1:0]   mem_dq
);

  localparam int PH_MAX = LATENCY + WAIT_TO + CS_HIGH_MIN;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int WC_W   = $clog2(BURST_LEN + 1);
  localparam int CS_W   = $clog2(MAX_CS_LOW + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  prd_state_e       st_q, st_nx;
  logic [PH_W-1:0]  ph_cnt;
  logic [WC_W-1:0]  wc_cnt;
  logic [CS_W-1:0]  cs_cnt;
  logic             accept, active, in_window, take, last_word, finish;
  logic             tmo_hit, lim_hit, lim_abort;
  logic             tmo_q, lim_q;
  logic             cs_n_q, adv_n_q, oe_n_q;
  logic [BE_W-1:0]  be_n_q;
  logic [AW-1:0]    addr_q;
  logic             act_nx;

  assign accept    = req_go && (st_q == ST_IDLE);
  assign active    = (st_q == ST_ADDR) || (st_q == ST_LAT) || (st_q == ST_DATA);
  assign in_window = (st_q == ST_LAT) && (ph_cnt >= PH_W'(LATENCY - 1));
  assign take      = (in_window || (st_q == ST_DATA)) && mem_wait_n;
  assign last_word = (wc_cnt == WC_W'(BURST_LEN - 1));
  assign finish    = take && last_word;
  assign tmo_hit   = (st_q == ST_LAT) && !mem_wait_n &&
                     (ph_cnt == PH_W'(LATENCY - 1 + WAIT_TO));
  assign lim_hit   = active && !cs_n_q && (cs_cnt == CS_W'(MAX_CS_LOW - 1));

  // next-state logic
  always_comb begin
    st_nx     = st_q;
    lim_abort = 1'b0;
    case (st_q)
      ST_IDLE:  if (accept) st_nx = ST_ADDR;
      ST_ADDR:  st_nx = ST_LAT;
      ST_LAT: begin
        if (finish)       st_nx = ST_RECOV;
        else if (take)    st_nx = ST_DATA;
        else if (tmo_hit) st_nx = ST_RECOV;
      end
      ST_DATA:  if (finish) st_nx = ST_RECOV;
      ST_RECOV: if (ph_cnt == PH_W'(CS_HIGH_MIN - 1)) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
    if (lim_hit && !finish && !tmo_hit) begin
      st_nx     = ST_RECOV;
      lim_abort = 1'b1;
    end
  end

  assign act_nx = (st_nx == ST_ADDR) || (st_nx == ST_LAT) || (st_nx == ST_DATA);

  // state and pin registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cs_n_q  <= 1'b1;
      adv_n_q <= 1'b1;
      oe_n_q  <= 1'b1;
      be_n_q  <= '1;
      tmo_q   <= 1'b0;
      lim_q   <= 1'b0;
    end else begin
      st_q    <= st_nx;
      cs_n_q  <= !act_nx;
      adv_n_q <= !(st_nx == ST_ADDR);
      oe_n_q  <= !act_nx;
      be_n_q  <= {BE_W{!act_nx}};
      if (accept)       tmo_q <= 1'b0;
      else if (tmo_hit) tmo_q <= 1'b1;
      if (accept)         lim_q <= 1'b0;
      else if (lim_abort) lim_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  // phase counter: latency window and recovery time
  prd_counter #(.W(PH_W)) u_phase (
    .clk (clk), .rst_n (rst_ni),
    .clr (st_nx != st_q), .en (1'b1),
    .cnt (ph_cnt)
  );

  // words taken in the current burst
  prd_counter #(.W(WC_W)) u_words (
    .clk (clk), .rst_n (rst_ni),
    .clr (accept), .en (take),
    .cnt (wc_cnt)
  );

  // cycles with chip select low
  prd_counter #(.W(CS_W)) u_cslow (
    .clk (clk), .rst_n (rst_ni),
    .clr (accept), .en (!cs_n_q),
    .cnt (cs_cnt)
  );

  prd_capture #(.DW(DW)) u_cap (
    .clk (clk), .rst_n (rst_ni),
    .take (take), .last (last_word), .dq_in (mem_dq),
    .rd_valid (rd_valid), .rd_data (rd_data), .rd_last (rd_last)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign tmo_err   = tmo_q;
  assign lim_err   = lim_q;
  assign mem_cs_n  = cs_n_q;
  assign mem_adv_n = adv_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_be_n  = be_n_q;
  assign mem_we_n  = 1'b1;
  assign mem_addr  = addr_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_go && busy) |=> $stable(mem_addr)); // R1

  AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !mem_adv_n |=> mem_adv_n); // R2

  AST_BURST_OPENS_WITH_ADV: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(mem_cs_n) |-> !mem_adv_n); // R2

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(mem_cs_n) |=> mem_cs_n); // R6

  AST_CS_LIMIT: assert property (@(posedge clk) disable iff (!rst_ni)
    !mem_cs_n |-> (cs_cnt < CS_W'(MAX_CS_LOW))); // R8

  AST_TMO_NO_DATA: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(tmo_err) |-> !rd_valid); // R7

  AST_DATA_ONLY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_valid |-> !$past(mem_cs_n)); // R9

endmodule

// File: tb/sim_psram_burst_reader.sv
module sim_psram_burst_reader;

  localparam int CLK_P = 10;
  localparam int AW    = 22;
  localparam int DW    = 16;
  localparam int LAT   = 5;
  localparam int BL    = 4;
  localparam int CHM   = 2;
  localparam int MAXC  = 20;
  localparam int WTO   = 3;

  logic          clk, rst_n, req_go;
  logic [AW-1:0] req_addr;
  logic          req_ready, busy, rd_valid, rd_last, tmo_err, lim_err;
  logic [DW-1:0] rd_data;
  logic          mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_wait_n;
  logic [1:0]    mem_be_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  psram_burst_reader #(
    .AW(AW), .DW(DW), .BE_W(2), .LATENCY(LAT), .BURST_LEN(BL),
    .CS_HIGH_MIN(CHM), .MAX_CS_LOW(MAXC), .WAIT_TO(WTO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_addr(req_addr),
    .req_ready(req_ready), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .tmo_err(tmo_err), .lim_err(lim_err),
    .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_wait_n(mem_wait_n), .mem_dq(mem_dq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // memory model: word w is ready LAT+m_extra edges after the address edge,
  // with an optional stall of m_st_len edges starting at word m_st_at
  int m_extra = 0, m_st_at = -1, m_st_len = 0;
  int cyc = 0;
  bit in_b = 0;
  logic [15:0] a_cap = '0;

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_adv_n) begin
      a_cap <= mem_addr[15:0];
      cyc   <= 0;
      in_b  <= 1'b1;
    end else if (mem_cs_n) begin
      in_b <= 1'b0;
    end else if (in_b) begin
      cyc <= cyc + 1;
    end
  end

  always @(negedge clk) begin
    int w, wp;
    bit stall;
    if (mem_cs_n) begin
      mem_wait_n = 1'b1;       // released line: must be ignored
      mem_dq     = 16'hDEAD;
    end else if (!in_b) begin
      mem_wait_n = 1'b0;
      mem_dq     = 16'h0BAD;
    end else begin
      w     = cyc + 1 - (LAT + m_extra);
      stall = (m_st_at >= 0) && (w >= m_st_at) && (w < m_st_at + m_st_len);
      if (w < 0 || stall) begin
        mem_wait_n = 1'b0;
        mem_dq     = 16'h0BAD;
      end else begin
        wp = (m_st_at >= 0 && w >= m_st_at + m_st_len) ? w - m_st_len : w;
        mem_wait_n = 1'b1;
        mem_dq     = a_cap + 16'(wp);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (req_ready) break;
    end
  endtask

  task automatic t_reset();
    chk(mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n, "R10", "strobes high", 0, 1);
    chk(mem_be_n == 2'b11, "R10", "byte enables", int'(mem_be_n), 3);
    chk(req_ready && !busy, "R10", "ready/busy", int'(busy), 0);
    chk(!rd_valid && !tmo_err && !lim_err, "R10", "valid/err", int'(rd_valid), 0);
  endtask

  // one burst, all results predicted from the requirement timing
  task automatic t_burst(input logic [AW-1:0] addr, input int extra,
                         input int st_at, input int st_len, input int poke,
                         input string name);
    int e[BL];
    int c, nw_exp, nw, cs_low, adv, bad_addr, bad_pin, busy_off;
    bit tmo_exp, lim_exp;
    tmo_exp = 0; lim_exp = 0;
    for (int j = 0; j < BL; j++)
      e[j] = 1 + LAT + extra + j + ((st_at >= 0 && j >= st_at) ? st_len : 0);
    if (extra > WTO) begin
      tmo_exp = 1; c = LAT + WTO + 1; nw_exp = 0;
    end else begin
      c = e[BL-1];
      if (c > MAXC) begin lim_exp = 1; c = MAXC; end
      nw_exp = 0;
      for (int j = 0; j < BL; j++) if (e[j] <= c) nw_exp++;
    end
    m_extra = extra; m_st_at = st_at; m_st_len = st_len;
    nw = 0; cs_low = 0; adv = 0; bad_addr = 0; bad_pin = 0; busy_off = 0;
    req_addr = addr;
    req_go   = 1'b1;
    for (int n = 1; n <= c + CHM + 6; n++) begin
      @(negedge clk);
      if (n == 1) req_go = 1'b0;
      if (n == poke) begin
        chk(!req_ready, "R1", {name, " ready while busy"}, int'(req_ready), 0);
        req_go = 1'b1; req_addr = addr ^ 22'h3;
      end
      if (n == poke + 1) begin req_go = 1'b0; req_addr = addr; end
      if (rd_valid) begin
        if (nw < BL) begin
          chk(n == e[nw] + 1, (nw == 0) ? "R3" : "R4",
              $sformatf("%s word %0d cycle", name, nw), n, e[nw] + 1);
          chk(rd_data == 16'(addr[15:0] + 16'(nw)), "R4",
              $sformatf("%s word %0d data", name, nw), int'(rd_data),
              int'(16'(addr[15:0] + 16'(nw))));
          chk(rd_last == (nw == BL - 1 && !lim_exp), "R4",
              $sformatf("%s word %0d last", name, nw), int'(rd_last),
              int'(nw == BL - 1 && !lim_exp));
        end
        nw++;
      end
      if (!mem_cs_n) begin
        cs_low++;
        if (mem_oe_n || mem_be_n != 2'b00) bad_pin++;
      end
      if (!mem_we_n) bad_pin++;
      if (!mem_adv_n) begin
        adv++;
        if (mem_addr != addr) bad_addr++;
      end
      if (!busy && busy_off == 0) busy_off = n;
    end
    chk(nw == nw_exp, tmo_exp ? "R7" : (lim_exp ? "R8" : "R4"),
        {name, " word count"}, nw, nw_exp);
    chk(cs_low == c, lim_exp ? "R8" : (tmo_exp ? "R7" : "R6"),
        {name, " cs low cycles"}, cs_low, c);
    chk(busy_off == c + CHM + 1, "R6", {name, " busy drop cycle"}, busy_off, c + CHM + 1);
    chk(adv == 1 && bad_addr == 0, "R2", {name, " adv cycles"}, adv, 1);
    chk(bad_pin == 0, "R5", {name, " oe/be/we"}, bad_pin, 0);
    chk(tmo_err == tmo_exp, "R7", {name, " tmo_err"}, int'(tmo_err), int'(tmo_exp));
    chk(lim_err == lim_exp, "R8", {name, " lim_err"}, int'(lim_err), int'(lim_exp));
    wait_idle();
  endtask

  // request held high: second burst waits out the chip-select recovery
  task automatic t_back_to_back();
    int words, adv, high, gap;
    bit seen_low, rose;
    m_extra = 0; m_st_at = -1; m_st_len = 0;
    words = 0; adv = 0; high = 0; gap = -1; seen_low = 0; rose = 0;
    req_addr = 22'h00_0040;
    req_go   = 1'b1;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (rd_valid) words++;
      if (!mem_adv_n) begin
        adv++;
        if (adv == 2) req_go = 1'b0;
      end
      if (!mem_cs_n) begin
        seen_low = 1;
        if (rose && gap < 0) gap = high;
      end else if (seen_low) begin
        rose = 1;
        high++;
      end
    end
    req_go = 1'b0;
    chk(gap == CHM + 1, "R6", "back-to-back cs high gap", gap, CHM + 1);
    chk(words == 2 * BL, "R4", "back-to-back words", words, 2 * BL);
    chk(adv == 2, "R2", "back-to-back adv strobes", adv, 2);
    wait_idle();
  endtask

  // idle: memory lines active with wait high while chip select is high
  task automatic t_idle_ignore();
    logic [DW-1:0] held;
    int bad;
    held = rd_data; bad = 0;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if (rd_valid || rd_data != held || !mem_cs_n) bad++;
    end
    chk(bad == 0, "R9", "idle wait/dq ignored", bad, 0);
  endtask

  initial begin
    #(CLK_P * 60000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_go = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_burst(22'h01_1200, 0, -1, 0, 0, "plain");
    t_burst(22'h00_0ff0, 2, -1, 0, 0, "delay2");
    t_burst(22'h2a_0010, WTO, -1, 0, 0, "delay-at-limit");
    t_burst(22'h00_0500, WTO + 1, -1, 0, 0, "timeout");
    t_burst(22'h00_0600, 0, -1, 0, 0, "after-timeout");
    t_burst(22'h00_0700, 0, 1, 3, 0, "stall");
    t_burst(22'h00_0800, 0, 2, 12, 0, "limit");
    t_burst(22'h00_0900, 1, -1, 0, 3, "go-while-busy");
    t_back_to_back();
    t_idle_ignore();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule